// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with End-of-Interrupt Modes

This block gathers eight level-sensitive interrupt request lines into a single interrupt output towards a processor. It samples the request lines into a request register, removes the masked ones, and picks the pending line with the lowest index. The output is raised only when that line outranks every level that is still being serviced. When the processor answers with an acknowledge strobe, the block returns an 8-bit vector. The vector joins a programmable base with the number of the winning level, and that level enters the in-service register.

Service of a level ends in one of three ways. An explicit end-of-interrupt command names the level to clear. An implicit command clears whichever in-service level has the highest priority. In automatic mode the level is never held in service past the acknowledge. A small write port programs the mask, the vector base and the mode, and carries the end-of-interrupt commands.

The control path is a three-state machine. IDLE means nothing is eligible and the output is low. PEND means the output is high and the block waits for an acknowledge. ACK lasts one cycle after an accepted acknowledge: the output is low and the vector is valid. The transitions are as follows. IDLE goes to PEND when a request is eligible. PEND goes to ACK on an accepted acknowledge, and back to IDLE if eligibility is lost. ACK goes to PEND if a request is eligible and to IDLE otherwise.

Top module: `prio_intc`

## Requirements
- R1: A synchronous reset clears the request and in-service registers, sets every mask bit, selects non-automatic mode and base 0, and leaves int_out and vec_vld low; with all lines masked, raised requests do not assert int_out.
- R2: A request that is unmasked and outranks every in-service level asserts int_out on the second rising edge after it appears on irq_in (first edge samples, second edge enters PEND).
- R3: Writing address 0 sets the mask; bit i = 1 blocks line i and bit i = 0 lets it through.
- R4: Priority is fixed with line 0 highest and line 7 lowest; the vector is {base, level}, with base taken from bits 7:3 of a write to address 1.
- R5: An acknowledge sampled while int_out is high makes vec_vld high for exactly the following cycle, with the vector on vec_out, and int_out is low in that cycle.
- R6: Outside automatic mode, an acknowledged level enters service; requests of equal or lower priority then keep int_out low, while a strictly higher-priority request still asserts it.
- R7: A write to address 3 with bit 7 = 0 is an explicit end-of-interrupt that clears the in-service bit named by bits 2:0, letting blocked requests assert int_out again.
- R8: A write to address 3 with bit 7 = 1 is an implicit end-of-interrupt that clears only the highest-priority in-service bit.
- R9: Writing address 2 with bit 0 = 1 selects automatic mode; an acknowledged level is not held in service, so a still-active request of the same level asserts int_out again without any command.
- R10: An explicit end-of-interrupt naming a level not in service, or an implicit one with nothing in service, changes nothing.
- R11: An acknowledge while int_out is low is ignored: vec_vld stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Level-sensitive request lines, bit 0 highest priority |
| wr_en | input | 1 | Write strobe for the configuration and command port |
| wr_addr | input | 2 | 0 mask, 1 vector base, 2 mode, 3 end-of-interrupt command |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Acknowledge strobe from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last accepted acknowledge |
| vec_vld | output | 1 | High for one cycle when vec_out carries a new vector |

## Verification
On every cycle the assertions check four things. The vector valid pulse lasts one cycle and only follows an accepted acknowledge. The output drops after an acknowledge. A returned level was unmasked and, outside automatic mode, is now in service. An in-service bit only falls after an end-of-interrupt write. Some behaviours can only be shown by the bench's scenarios: that equal and lower levels stay blocked while a higher one preempts, which bit an implicit command picks, that commands naming nothing leave the state alone, and that automatic mode re-raises a held line. The bench shows these by comparing against its reference model and by directed checks of the output after each step.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACK  = 2'd2
    } intc_state_e;

    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_BASE = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
    localparam logic [1:0] ADDR_EOI  = 2'd3;
endpackage

// File: rtl/intc_pick.sv
// Lowest-index set bit finder (index 0 has the highest priority).
module intc_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_cfg.sv
// Write port decode: mask, vector base, mode, and end-of-interrupt commands.
module intc_cfg #(
    parameter int N      = 8,
    parameter int LVL_W  = $clog2(N),
    parameter int VEC_W  = 8,
    parameter int BASE_W = VEC_W - LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    output logic [N-1:0]      imr,
    output logic [BASE_W-1:0] base,
    output logic              aeoi,
    output logic              eoi_cmd,
    output logic              eoi_implicit,
    output logic [LVL_W-1:0]  eoi_level
);
    import intc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            imr  <= '1;
            base <= '0;
            aeoi <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_MASK: imr  <= wr_data[N-1:0];
                ADDR_BASE: base <= wr_data[VEC_W-1:LVL_W];
                ADDR_MODE: aeoi <= wr_data[0];
                ADDR_EOI:  ;
            endcase
        end
    end

    always_comb begin
        eoi_cmd      = wr_en && (wr_addr == ADDR_EOI);
        eoi_implicit = wr_data[VEC_W-1];
        eoi_level    = wr_data[LVL_W-1:0];
    end
endmodule

// File: rtl/intc_isr.sv
// In-service register: set on acknowledge, cleared by end-of-interrupt.
module intc_isr #(
    parameter int N     = 8,
    parameter int LVL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [LVL_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic             clr_implicit,
    input  logic [LVL_W-1:0] clr_idx,
    input  logic             top_any,
    input  logic [LVL_W-1:0] top_idx,
    output logic [N-1:0]     isr
);
    logic [N-1:0] clr_mask;
    logic [N-1:0] set_mask;
    logic [N-1:0] one;

    always_comb begin
        one      = {{(N-1){1'b0}}, 1'b1};
        clr_mask = '0;
        if (clr_en) begin
            if (clr_implicit) begin
                if (top_any) clr_mask = one << top_idx;
            end else begin
                clr_mask = one << clr_idx;
            end
        end
        set_mask = set_en ? (one << set_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (isr & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/intc_fsm.sv
// Output handshake state machine.
module intc_fsm (
    input  logic clk,
    input  logic rst,
    input  logic eligible,
    input  logic ack,
    output logic fire,
    output logic int_out
);
    import intc_pkg::*;

    intc_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = eligible ? ST_PEND : ST_IDLE;
            ST_PEND: begin
                if (ack && eligible) state_nx = ST_ACK;
                else if (!eligible)  state_nx = ST_IDLE;
                else                 state_nx = ST_PEND;
            end
            ST_ACK:  state_nx = eligible ? ST_PEND : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        int_out = (state == ST_PEND);
        fire    = (state == ST_PEND) && ack && eligible;
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             ack,
    output logic             int_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_vld
);
    localparam int LVL_W  = $clog2(N_IRQ);
    localparam int BASE_W = VEC_W - LVL_W;

    logic [N_IRQ-1:0]  irr_q;
    logic [N_IRQ-1:0]  imr_q;
    logic [N_IRQ-1:0]  isr_q;
    logic [N_IRQ-1:0]  pending;
    logic [BASE_W-1:0] base_q;
    logic              aeoi_q;
    logic              eoi_cmd, eoi_implicit;
    logic [LVL_W-1:0]  eoi_level;
    logic              pend_any, isr_any;
    logic [LVL_W-1:0]  win_idx, isr_top;
    logic              eligible, fire;

    intc_cfg #(.N(N_IRQ), .LVL_W(LVL_W), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .imr(imr_q), .base(base_q), .aeoi(aeoi_q),
        .eoi_cmd(eoi_cmd), .eoi_implicit(eoi_implicit), .eoi_level(eoi_level)
    );

    assign pending = irr_q & ~imr_q;

    intc_pick #(.N(N_IRQ), .W(LVL_W)) u_pick_req (
        .req(pending), .any(pend_any), .idx(win_idx)
    );

    intc_pick #(.N(N_IRQ), .W(LVL_W)) u_pick_isr (
        .req(isr_q), .any(isr_any), .idx(isr_top)
    );

    assign eligible = pend_any && (!isr_any || (win_idx < isr_top));

    intc_fsm u_fsm (
        .clk(clk), .rst(rst), .eligible(eligible), .ack(ack),
        .fire(fire), .int_out(int_out)
    );

    intc_isr #(.N(N_IRQ), .LVL_W(LVL_W)) u_isr (
        .clk(clk), .rst(rst),
        .set_en(fire && !aeoi_q), .set_idx(win_idx),
        .clr_en(eoi_cmd), .clr_implicit(eoi_implicit), .clr_idx(eoi_level),
        .top_any(isr_any), .top_idx(isr_top),
        .isr(isr_q)
    );

    // Level-sensitive request register; the acknowledged line is dropped for one cycle.
    always_ff @(posedge clk) begin
        if (rst) irr_q <= '0;
        else     irr_q <= irq_in & ~(fire ? ({{(N_IRQ-1){1'b0}}, 1'b1} << win_idx) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= fire;
            if (fire) vec_out <= {base_q, win_idx};
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             int_out,
    input logic             vec_vld,
    input logic [VEC_W-1:0] vec_out,
    input logic [N_IRQ-1:0] imr_q,
    input logic [N_IRQ-1:0] isr_q,
    input logic             aeoi_q
);
    localparam int LVL_W = $clog2(N_IRQ);

    logic [N_IRQ-1:0] imr_d;
    logic             aeoi_d;

    always_ff @(posedge clk) begin
        imr_d  <= imr_q;
        aeoi_d <= aeoi_q;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!int_out && !vec_vld));

    a_r5_int_drops_after_ack: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out) |=> !int_out);

    a_r5_vld_single_cycle: assert property (@(posedge clk) disable iff (rst)
        vec_vld |=> !vec_vld);

    a_r11_vld_needs_ack: assert property (@(posedge clk) disable iff (rst)
        vec_vld |-> $past(ack && int_out));

    a_r3_vector_unmasked: assert property (@(posedge clk) disable iff (rst)
        vec_vld |-> !imr_d[vec_out[LVL_W-1:0]]);

    a_r6_level_in_service: assert property (@(posedge clk) disable iff (rst)
        (vec_vld && !aeoi_d) |-> isr_q[vec_out[LVL_W-1:0]]);

    a_r7_clear_only_by_eoi: assert property (@(posedge clk) disable iff (rst)
        (|($past(isr_q) & ~isr_q)) |-> $past(wr_en && (wr_addr == 2'd3)));
endmodule

bind prio_intc prio_intc_chk #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .wr_en(wr_en), .wr_addr(wr_addr),
    .int_out(int_out), .vec_vld(vec_vld), .vec_out(vec_out),
    .imr_q(imr_q), .isr_q(isr_q), .aeoi_q(aeoi_q)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_intc dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ack(ack), .int_out(int_out), .vec_out(vec_out), .vec_vld(vec_vld)
    );

    // Behavioural reference model
    int m_irr, m_isr, m_imr, m_base, m_aeoi, m_st, m_vec, m_vld;

    function automatic int lowest(int v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    always @(posedge clk) begin
        int pend, win, hi, elig, fire, isr_n;
        if (rst) begin
            m_irr = 0; m_isr = 0; m_imr = 255; m_base = 0; m_aeoi = 0;
            m_st = 0; m_vec = 0; m_vld = 0;
        end else begin
            pend  = m_irr & ~m_imr & 255;
            win   = lowest(pend);
            hi    = lowest(m_isr);
            elig  = (win < 8 && win < hi) ? 1 : 0;
            fire  = (ack && m_st == 1 && elig) ? 1 : 0;
            isr_n = m_isr;
            if (wr_en && wr_addr == 3) begin
                if (wr_data[7]) begin
                    if (hi < 8) isr_n = isr_n & ~(1 << hi);
                end else begin
                    isr_n = isr_n & ~(1 << wr_data[2:0]);
                end
            end
            if (fire && !m_aeoi) isr_n = isr_n | (1 << win);
            m_irr = int'(irq_in) & ~(fire ? (1 << win) : 0);
            if (fire) m_vec = m_base * 8 + win;
            m_vld = fire;
            if (m_st == 1) m_st = fire ? 2 : (elig ? 1 : 0);
            else           m_st = elig ? 1 : 0;
            m_isr = isr_n;
            if (wr_en && wr_addr == 0) m_imr = int'(wr_data);
            if (wr_en && wr_addr == 1) m_base = int'(wr_data[7:3]);
            if (wr_en && wr_addr == 2) m_aeoi = int'(wr_data[0]);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(int_out) != (m_st == 1 ? 1 : 0)) begin
                failures++;
                $display("FAIL R2 model int_out: actual %0d expected %0d at %0t", int_out, m_st == 1, $time);
            end
            checks++;
            if (int'(vec_vld) != m_vld || (vec_vld && int'(vec_out) != m_vec)) begin
                failures++;
                $display("FAIL R4 model vector: actual vld=%0d vec=%0h expected vld=%0d vec=%0h at %0t",
                         vec_vld, vec_out, m_vld, m_vec, $time);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 int_out after reset", int'(int_out), 0);
        chk("R1 vec_vld after reset", int'(vec_vld), 0);
        irq_in = 8'hFF;
        settle(4);
        chk("R1 all masked keeps int low", int'(int_out), 0);
        irq_in = 8'h00;
        wr(2'd1, 8'hA8);
        wr(2'd0, 8'h00);
        settle(2);

        // R2 latency, R4 priority and vector
        irq_in = 8'h24;
        @(negedge clk);
        chk("R2 int low after first edge", int'(int_out), 0);
        @(negedge clk);
        chk("R2 int high after second edge", int'(int_out), 1);
        ack_pulse();
        chk("R5 vec_vld after ack", int'(vec_vld), 1);
        chk("R4 vector for level 2", int'(vec_out), 8'hAA);
        chk("R5 int low in ack cycle", int'(int_out), 0);
        @(negedge clk);
        chk("R5 vec_vld one cycle", int'(vec_vld), 0);

        settle(4);
        chk("R6 equal and lower blocked", int'(int_out), 0);
        irq_in = 8'h25;
        settle(2);
        chk("R6 higher preempts", int'(int_out), 1);
        ack_pulse();
        chk("R4 vector for level 0", int'(vec_out), 8'hA8);
        irq_in = 8'h24;
        settle(3);

        wr(2'd3, 8'h80);
        settle(3);
        chk("R8 implicit clears only top level", int'(int_out), 0);
        wr(2'd3, 8'h06);
        settle(3);
        chk("R10 explicit on idle level no effect", int'(int_out), 0);
        wr(2'd3, 8'h02);
        settle(2);
        chk("R7 explicit reopens level 2", int'(int_out), 1);
        ack_pulse();
        chk("R7 vector after reopen", int'(vec_out), 8'hAA);
        wr(2'd3, 8'h02);

        // R3 mask
        irq_in = 8'h00;
        settle(3);
        wr(2'd0, 8'h20);
        irq_in = 8'h20;
        settle(4);
        chk("R3 masked line blocked", int'(int_out), 0);
        irq_in = 8'h30;
        settle(3);
        chk("R3 unmasked line raises", int'(int_out), 1);
        ack_pulse();
        chk("R3 vector for level 4", int'(vec_out), 8'hAC);
        irq_in = 8'h00;
        wr(2'd3, 8'h80);
        wr(2'd0, 8'h00);
        settle(3);

        // R9 automatic mode
        wr(2'd2, 8'h01);
        irq_in = 8'h20;
        settle(3);
        chk("R9 int raised", int'(int_out), 1);
        ack_pulse();
        chk("R9 vector for level 5", int'(vec_out), 8'hAD);
        settle(3);
        chk("R9 same level re-raises", int'(int_out), 1);
        ack_pulse();
        irq_in = 8'h00;
        settle(3);
        wr(2'd3, 8'h80);
        settle(2);
        chk("R10 implicit on empty no effect", int'(int_out), 0);

        // R11 stray acknowledge
        ack_pulse();
        chk("R11 ack ignored when idle", int'(vec_vld), 0);
        settle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule